// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

A bank of independent interval timers for a small audio-processor subsystem. A shared clock-enable input feeds two free-running prescalers, a slow one and a fast one, and each prescaler emits a one-cycle tick strobe. Every channel takes the tick of its assigned prescaler. While the channel is enabled, each tick advances an 8-bit divider. When the divider reaches the programmed period, it returns to zero and a 4-bit event counter advances.

Software sets each channel's period through a target-write strobe and samples the event counter through a read strobe. A read returns the counter value shown on `cnt_val` in that cycle and clears the counter. Setting a channel's enable bit restarts it from zero. Clearing the enable bit freezes the channel where it stands.

Top module: `prescaled_timer_bank`

## Requirements
- R1: Synchronous active-high reset clears every enable history, divider and counter, and sets every target to 0, so the period is 256.
- R2: A prescaler emits a tick in the cycle of every DIV-th asserted `clk_en` since reset, counted in cycles where `clk_en` is 1. Channels whose bit in `FAST_MASK` is 0 use DIV = `SLOW_DIV`, and channels whose bit is 1 use `FAST_DIV`. By default the last channel is the fast one.
- R3: A target of N from 1 to 255 gives one counter advance every N ticks of an enabled channel. A target of 0 gives one advance every 256 ticks.
- R4: The counter is 4 bits wide. It wraps from 15 to 0, and channel i shows it on `cnt_val[4i+3:4i]`.
- R5: With `cnt_rd[i]` high in a cycle, `cnt_val` in that cycle is the value returned. From the next cycle the counter reads 0.
- R6: If a read and a counter advance fall in the same cycle, the read returns the value before the advance and the counter then reads 1.
- R7: In the cycle where `tmr_en[i]` is 1 after being 0 in the previous cycle, the divider and the counter are forced to zero. This takes priority over a tick and over a read.
- R8: While `tmr_en[i]` is 0, ticks are ignored and the divider and counter hold their values. A read still clears the counter.
- R9: A target write (`tgt_wr[i]`, value on `tgt_data`) leaves the divider unchanged. The new period applies from the next cycle. If the divider already lies at or above the new period, it keeps counting to 255 and wraps to 0 without a counter advance.
- R10: The channels are independent. Enable bit i, write strobe i and read strobe i act only on channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Common clock enable feeding the prescalers |
| tmr_en | input | NUM_TMR | Per-channel enable, bit i for channel i |
| tgt_wr | input | NUM_TMR | Per-channel target write strobe |
| tgt_data | input | 8 | Target value written by `tgt_wr` |
| cnt_rd | input | NUM_TMR | Per-channel destructive counter read strobe |
| cnt_val | output | 4*NUM_TMR | Packed counter values, channel i at bits [4i+3:4i] |

## Verification
The bench builds the bank with `SLOW_DIV` = 8 and `FAST_DIV` = 4 instead of 128 and 16. This lets a 256-tick period complete in a few thousand cycles. It also makes counter wraps past 15 and collisions between reads and advances common in random runs. A directed phase on the fast channel uses a target of 1 and reads every cycle. With that setup, every tick produces a collision between a read and an advance. Other phases lower a target beneath the live divider, and toggle enables while ticks arrive.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int TGT_W = 8;
  localparam int CNT_W = 4;
  localparam int PER_W = TGT_W + 1;

  // Zero target stands for the full 2**TGT_W tick period.
  function automatic logic [PER_W-1:0] period_of(input logic [TGT_W-1:0] tgt);
    return (tgt == '0) ? PER_W'(1 << TGT_W) : {1'b0, tgt};
  endfunction

  // Divider step: returns {match, next divider value}.
  function automatic logic [TGT_W:0] div_step(input logic [TGT_W-1:0] div,
                                               input logic [PER_W-1:0] per);
    logic [PER_W-1:0] nxt;
    nxt = {1'b0, div} + PER_W'(1);
    if (nxt == per) return {1'b1, {TGT_W{1'b0}}};
    return {1'b0, nxt[TGT_W-1:0]};
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] pre_q;
  logic         at_end;

  assign at_end = (pre_q == W'(DIV - 1));
  assign tick   = clk_en && at_end;

  always_ff @(posedge clk) begin
    if (rst)         pre_q <= '0;
    else if (clk_en) pre_q <= at_end ? '0 : pre_q + W'(1);
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             tgt_wr,
  input  logic [TGT_W-1:0] tgt_data,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] cnt_val
);
  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  // Named internal events
  logic             rise;
  logic             step;
  logic             match;
  logic [TGT_W:0]   stepped;

  assign rise    = en && !en_q;
  assign step    = en && tick && !rise;
  assign stepped = div_step(div_q, period_of(tgt_q));
  assign match   = step && stepped[TGT_W];
  assign cnt_val = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en;
      if (tgt_wr) tgt_q <= tgt_data;
      if (rise) begin
        div_q <= '0;
        cnt_q <= '0;
      end else begin
        if (step) div_q <= stepped[TGT_W-1:0];
        if (cnt_rd)     cnt_q <= match ? CNT_W'(1) : '0;
        else if (match) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt_q == '0 && div_q == '0)); // R7
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && !match && !rise) |=> cnt_q == '0); // R5
  AST_READ_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && match) |=> cnt_q == CNT_W'(1)); // R6
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_rd) |=> ($stable(cnt_q) && $stable(div_q))); // R8
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cnt_rd && !rise) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R4
endmodule

// File: rtl/prescaled_timer_bank.sv
module prescaled_timer_bank
  import timer_pkg::*;
#(
  parameter int               NUM_TMR   = 3,
  parameter int               SLOW_DIV  = 128,
  parameter int               FAST_DIV  = 16,
  parameter logic [NUM_TMR-1:0] FAST_MASK = NUM_TMR'(1) << (NUM_TMR - 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic [NUM_TMR-1:0]       tmr_en,
  input  logic [NUM_TMR-1:0]       tgt_wr,
  input  logic [TGT_W-1:0]         tgt_data,
  input  logic [NUM_TMR-1:0]       cnt_rd,
  output logic [NUM_TMR*CNT_W-1:0] cnt_val
);
  logic slow_tick;
  logic fast_tick;

  tick_prescaler #(.DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tick(slow_tick));
  tick_prescaler #(.DIV(FAST_DIV)) u_fast (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tick(fast_tick));

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
      logic ch_tick;
      assign ch_tick = FAST_MASK[i] ? fast_tick : slow_tick;
      timer_channel u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick    (ch_tick),
        .en      (tmr_en[i]),
        .tgt_wr  (tgt_wr[i]),
        .tgt_data(tgt_data),
        .cnt_rd  (cnt_rd[i]),
        .cnt_val (cnt_val[i*CNT_W +: CNT_W])
      );
    end
  endgenerate
endmodule

// File: tb/prescaled_timer_bank_test.sv
module prescaled_timer_bank_test;
  localparam int N    = 3;
  localparam int SLOW = 8;
  localparam int FAST = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clk_en = 1'b0;
  logic [N-1:0] tmr_en = '0;
  logic [N-1:0] tgt_wr = '0;
  logic [7:0]   tgt_data = '0;
  logic [N-1:0] cnt_rd = '0;
  logic [4*N-1:0] cnt_val;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model state
  int m_div[N];
  int m_cnt[N];
  int m_tgt[N];
  bit m_enq[N];
  int ps_slow;
  int ps_fast;

  prescaled_timer_bank #(.NUM_TMR(N), .SLOW_DIV(SLOW), .FAST_DIV(FAST)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tmr_en(tmr_en), .tgt_wr(tgt_wr),
    .tgt_data(tgt_data), .cnt_rd(cnt_rd), .cnt_val(cnt_val));

  always #2.5 clk = ~clk;

  function automatic int ticks_per_count(input int t);
    if (t == 0) return 256;
    return t;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_div[i] = 0; m_cnt[i] = 0; m_tgt[i] = 0; m_enq[i] = 0;
    end
    ps_slow = 0; ps_fast = 0;
  endtask

  task automatic model_update();
    bit ts, tf;
    ts = clk_en && (ps_slow == SLOW - 1);
    tf = clk_en && (ps_fast == FAST - 1);
    if (clk_en) begin
      ps_slow = (ps_slow + 1) % SLOW;
      ps_fast = (ps_fast + 1) % FAST;
    end
    for (int i = 0; i < N; i++) begin
      bit tk, adv;
      tk  = (i == N - 1) ? tf : ts;
      adv = 0;
      if (tmr_en[i] && !m_enq[i]) begin
        m_div[i] = 0; m_cnt[i] = 0;
      end else begin
        if (tmr_en[i] && tk) begin
          if (m_div[i] + 1 == ticks_per_count(m_tgt[i])) begin
            m_div[i] = 0; adv = 1;
          end else m_div[i] = (m_div[i] + 1) % 256;
        end
        if (cnt_rd[i]) m_cnt[i] = adv ? 1 : 0;
        else if (adv)  m_cnt[i] = (m_cnt[i] + 1) % 16;
      end
      if (tgt_wr[i]) m_tgt[i] = tgt_data;
      m_enq[i] = tmr_en[i];
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < N; i++) begin
      int got;
      got = cnt_val[i*4 +: 4];
      checks++;
      if (got != m_cnt[i]) begin
        failures++;
        $display("FAIL %s ch%0d cnt_val actual=%0d expected=%0d t=%0t",
                 tag, i, got, m_cnt[i], $time);
      end
    end
  endtask

  // One clock: check outputs, drive new inputs, advance model.
  task automatic cycle(input string tag, input bit ce, input logic [N-1:0] en,
                       input logic [N-1:0] wr, input logic [7:0] d,
                       input logic [N-1:0] rd);
    @(negedge clk);
    compare(tag);
    clk_en = ce; tmr_en = en; tgt_wr = wr; tgt_data = d; cnt_rd = rd;
    model_update();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    compare("R1 reset");
    model_update();

    // R1: zero target means 256-tick period on slow channel 0
    for (int c = 0; c < 2 * 256 * SLOW + 20; c++)
      cycle("R1 R3 default period", 1, 3'b001, 0, 0, 0);

    // R3 R2: small targets on every channel, steady clk_en
    cycle("R9 write", 1, 3'b000, 3'b111, 8'd3, 0);
    for (int c = 0; c < 600; c++)
      cycle("R2 R3 R4 target three", 1, 3'b111, 0, 0, 0);

    // R6: fast channel target 1, read every cycle, collisions each tick
    cycle("R7 restart", 1, 3'b000, 3'b100, 8'd1, 0);
    for (int c = 0; c < 200; c++)
      cycle("R6 collide", 1, 3'b100, 0, 0, 3'b100);

    // R4: wrap 15 -> 0 without reads
    for (int c = 0; c < 200; c++)
      cycle("R4 wrap", 1, 3'b100, 0, 0, 0);

    // R8: disable and keep ticking, then read while off
    for (int c = 0; c < 100; c++)
      cycle("R8 frozen", 1, 3'b000, 0, 0, 0);
    cycle("R8 read while off", 1, 3'b000, 0, 0, 3'b111);
    cycle("R5 cleared", 1, 3'b000, 0, 0, 0);

    // R9: lower target beneath live divider on channel 0
    cycle("R9 set", 1, 3'b000, 3'b001, 8'd40, 0);
    for (int c = 0; c < 30 * SLOW; c++)
      cycle("R9 run", 1, 3'b001, 0, 0, 0);
    cycle("R9 lower", 1, 3'b001, 3'b001, 8'd5, 0);
    for (int c = 0; c < 256 * SLOW + 200; c++)
      cycle("R9 wrap divider", 1, 3'b001, 0, 0, 0);

    // R10 R5 R6 R7 R8: random mix
    for (int c = 0; c < 60000; c++) begin
      logic [N-1:0] en, wr, rd;
      logic [7:0] d;
      bit ce;
      ce = ($urandom % 8) != 0;
      en = tmr_en;
      if (($urandom % 64) == 0) en[$urandom % N] = ~en[$urandom % N];
      wr = (($urandom % 50) == 0) ? N'(1 << ($urandom % N)) : '0;
      d  = (($urandom % 4) == 0) ? 8'(($urandom % 3)) : 8'($urandom % 12);
      rd = (($urandom % 10) == 0) ? N'($urandom) : '0;
      cycle("R10 random", ce, en, wr, d, rd);
    end

    @(negedge clk);
    compare("R10 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule